// File: doc/BRIEF.md
# Processor Execution Trace Port

This block sits next to a small multitasking processor core. On every clock it captures a 16-bit status word from the core: the two flags, the pipeline-advance indication, the condition result, the not-cancelled indication, the task number and the program counter. It drives that word onto one 16-bit group of a wider general-purpose pin bank. A configuration write turns the trace on or off and chooses the group. Only that group's output enables are raised, and all other pins are left alone. The trace is on, on group 0, when reset ends. It therefore works on a part where little else has been brought up. A security lock input forces the trace off and keeps it off.

The same block provides a pin-driven debug control path that feeds a stall request back into the core pipeline. With single-step mode enabled, the pipeline is held, and each rising edge on the step input releases it for exactly one cycle. With the breakpoint enabled, the stall is raised in the same cycle the core program counter equals the breakpoint address. The stall stays latched until a step pulse arrives or the breakpoint enable drops. The trace pins are a plain continuous output with no back-pressure: the pins cannot refuse a word, and a new word replaces the old one on every clock.

Top module: `exec_trace_port`

## Requirements
- R1: The trace word is packed, from bit 15 down to bit 0, as: zero flag [15], carry flag [14], advance/GO [13], condition result [12], not-cancelled/VALID [11], task number [10:9], program counter [8:0].
- R2: The core status sampled at a rising clock edge appears on the pins after that edge, and not before. This gives a lag of exactly one clock, and the pins refresh on every clock.
- R3: After reset the trace is enabled on group 0 (pins 15..0), and no stall is requested while single-step and breakpoint are off.
- R4: A write with `cfg_we` high loads `cfg_en` and `cfg_sel`, and takes effect from the next clock. Group k occupies pins [16k+15:16k].
- R5: Pins outside the selected group have output enable 0 and data 0. When the trace is disabled, every pin has output enable 0 and data 0.
- R6: While `sec_lock` is high, every output enable and every data pin is 0 in the same cycle, and a configuration write cannot turn the trace on. Once the lock is released, the stored configuration applies.
- R7: With `dbg_se` high, `stall_req` is high except for exactly one cycle per rising edge of `dbg_step`, however long the step input is held. That cycle follows a two-flop synchronizer.
- R8: With `dbg_be` high, `stall_req` rises in the same cycle that `core_pc` equals `dbg_brk`. With both debug enables low, `stall_req` is 0.
- R9: A breakpoint hit holds `stall_req` high, even if the PC moves, until a step pulse or until `dbg_be` goes low. It is released in that cycle.
- R10: After a release, the breakpoint does not fire again at the same address until the PC has first differed from `dbg_brk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_z | input | 1 | Core zero flag |
| core_c | input | 1 | Core carry flag |
| core_go | input | 1 | High while the pipeline advances |
| core_cond | input | 1 | Condition result of the current instruction |
| core_valid | input | 1 | Low when the instruction is cancelled behind a taken branch |
| core_task | input | 2 | Current task number |
| core_pc | input | 9 | Current program counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Trace enable value to write |
| cfg_sel | input | 2 | Pin group index to write |
| sec_lock | input | 1 | Security lock; forces the trace off |
| dbg_se | input | 1 | Single-step mode enable |
| dbg_step | input | 1 | Asynchronous step request (rising edge) |
| dbg_be | input | 1 | Breakpoint enable |
| dbg_brk | input | 9 | Breakpoint address |
| pin_out | output | 64 | Pin bank data |
| pin_oe | output | 64 | Pin bank output enables |
| stall_req | output | 1 | Stall request to the core pipeline |

## Verification
Several properties are checked on every cycle:
- Either no pin or exactly one full 16-pin group is enabled.
- No data is driven on a pin that is not enabled.
- The security lock darkens all pins at once.
- A synchronized step pulse never lasts two cycles.
- A breakpoint hit keeps the stall asserted until a release condition occurs.
- With both debug modes off, no stall is requested.

Only the directed scenarios can show the following:
- The bit layout and one-clock lag of the trace word.
- Relocation of the word to each group.
- A long step pulse freeing exactly one cycle.
- The rule that the breakpoint must be passed before it fires again.

// File: rtl/etp_pkg.sv
package etp_pkg;
  localparam int PC_W   = 9;
  localparam int TASK_W = 2;
  localparam int WORD_W = 5 + TASK_W + PC_W;

  typedef struct packed {
    logic              z;
    logic              c;
    logic              go;
    logic              cond;
    logic              valid;
    logic [TASK_W-1:0] tsk;
    logic [PC_W-1:0]   pc;
  } trace_word_t;
endpackage

// File: rtl/etp_cfg.sv
module etp_cfg #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             en_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             lock,
  output logic             active,
  output logic [SEL_W-1:0] sel
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b1;
      sel  <= '0;
    end else if (we) begin
      en_q <= en_in;
      sel  <= sel_in;
    end
  end

  assign active = en_q & ~lock;
endmodule

// File: rtl/etp_pin_mux.sv
module etp_pin_mux #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int SEL_W     = 2,
  localparam int BANK_W   = NUM_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] word,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_oe
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic hit;
    assign hit = active && (sel == SEL_W'(k));
    assign pin_out[k*WORD_W +: WORD_W] = hit ? word : '0;
    assign pin_oe[k*WORD_W +: WORD_W]  = hit ? '1 : '0;
  end

  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pin_oe) == 0) || ($countones(pin_oe) == WORD_W)); // R5
  AST_NO_UNDRIVEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R5
endmodule

// File: rtl/etp_step_sync.sv
module etp_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_async,
  output logic step_pulse
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], step_async};
  end

  assign step_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse); // R7
endmodule

// File: rtl/etp_brkpt.sv
module etp_brkpt #(
  parameter int PC_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc,
  input  logic            se,
  input  logic            be,
  input  logic [PC_W-1:0] brk,
  input  logic            step_pulse,
  output logic            stall_req
);
  logic hold_q, armed_q, match, hit;

  assign match = (pc == brk);
  assign hit   = be & armed_q & match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (!be)                      hold_q <= 1'b0;
      else if (hold_q & step_pulse) hold_q <= 1'b0;
      else if (hit)                 hold_q <= 1'b1;
      if (hit)         armed_q <= 1'b0;
      else if (!match) armed_q <= 1'b1;
    end
  end

  assign stall_req = (se & ~step_pulse) | (hold_q & be & ~step_pulse) | hit;

  AST_BP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (stall_req || step_pulse || !be)); // R9
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!se && !be) |-> !stall_req); // R8
endmodule

// File: rtl/exec_trace_port.sv
module exec_trace_port #(
  parameter int NUM_WORDS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = etp_pkg::WORD_W,
  localparam int PC_W   = etp_pkg::PC_W,
  localparam int TASK_W = etp_pkg::TASK_W,
  localparam int SEL_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BANK_W = NUM_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_z,
  input  logic              core_c,
  input  logic              core_go,
  input  logic              core_cond,
  input  logic              core_valid,
  input  logic [TASK_W-1:0] core_task,
  input  logic [PC_W-1:0]   core_pc,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              sec_lock,
  input  logic              dbg_se,
  input  logic              dbg_step,
  input  logic              dbg_be,
  input  logic [PC_W-1:0]   dbg_brk,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_oe,
  output logic              stall_req
);
  etp_pkg::trace_word_t trace_q;
  logic                 active;
  logic [SEL_W-1:0]     sel;
  logic                 step_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) trace_q <= '0;
    else begin
      trace_q.z     <= core_z;
      trace_q.c     <= core_c;
      trace_q.go    <= core_go;
      trace_q.cond  <= core_cond;
      trace_q.valid <= core_valid;
      trace_q.tsk   <= core_task;
      trace_q.pc    <= core_pc;
    end
  end

  etp_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .en_in(cfg_en), .sel_in(cfg_sel),
    .lock(sec_lock), .active(active), .sel(sel)
  );

  etp_pin_mux #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .active(active), .sel(sel), .word(trace_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  etp_step_sync #(.STAGES(SYNC_STAGES)) u_step (
    .clk(clk), .rst_n(rst_n), .step_async(dbg_step), .step_pulse(step_pulse)
  );

  etp_brkpt #(.PC_W(PC_W)) u_bp (
    .clk(clk), .rst_n(rst_n), .pc(core_pc), .se(dbg_se), .be(dbg_be),
    .brk(dbg_brk), .step_pulse(step_pulse), .stall_req(stall_req)
  );

  AST_LOCK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_lock |-> (pin_oe == '0 && pin_out == '0)); // R6
endmodule

// File: tb/exec_trace_port_tb.sv
module exec_trace_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_z = 0, core_c = 0, core_go = 0, core_cond = 0, core_valid = 0;
  logic [1:0] core_task = '0;
  logic [8:0] core_pc = '0;
  logic cfg_we = 0, cfg_en = 0;
  logic [1:0] cfg_sel = '0;
  logic sec_lock = 0, dbg_se = 0, dbg_step = 0, dbg_be = 0;
  logic [8:0] dbg_brk = '0;
  logic [63:0] pin_out, pin_oe;
  logic stall_req;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  exec_trace_port u_dut (
    .clk(clk), .rst_n(rst_n), .core_z(core_z), .core_c(core_c), .core_go(core_go),
    .core_cond(core_cond), .core_valid(core_valid), .core_task(core_task),
    .core_pc(core_pc), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .sec_lock(sec_lock), .dbg_se(dbg_se), .dbg_step(dbg_step), .dbg_be(dbg_be),
    .dbg_brk(dbg_brk), .pin_out(pin_out), .pin_oe(pin_oe), .stall_req(stall_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pack(input bit z, c, go, cond, valid,
                                       input logic [1:0] t, input logic [8:0] pc);
    return {z, c, go, cond, valid, t, pc};
  endfunction

  function automatic logic [63:0] grp(input int k, input logic [15:0] w);
    return {48'h0, w} << (16 * k);
  endfunction

  task automatic drive_core(input bit z, c, go, cond, valid,
                            input logic [1:0] t, input logic [8:0] pc);
    core_z = z; core_c = c; core_go = go; core_cond = cond; core_valid = valid;
    core_task = t; core_pc = pc;
  endtask

  task automatic cfg_write(input bit en, input logic [1:0] sel);
    @(posedge clk) #1; cfg_we = 1; cfg_en = en; cfg_sel = sel;
    @(posedge clk) #1; cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pin_oe == grp(0, 16'hFFFF), "R3 oe after reset", pin_oe, grp(0, 16'hFFFF));
    chk(stall_req == 0, "R3 no stall after reset", {63'h0, stall_req}, 64'h0);
  endtask

  task automatic t_layout();
    logic [15:0] w1, w2;
    @(posedge clk) #1; drive_core(1, 0, 0, 0, 0, 2'd0, 9'h000);
    w1 = 16'h8000;
    @(posedge clk); @(negedge clk);
    chk(pin_out == grp(0, w1), "R1 zero flag at bit 15", pin_out, grp(0, w1));
    @(posedge clk) #1; drive_core(0, 1, 1, 0, 1, 2'd2, 9'h155);
    w2 = pack(0, 1, 1, 0, 1, 2'd2, 9'h155);
    @(negedge clk);
    chk(pin_out == grp(0, w1), "R2 old word before edge", pin_out, grp(0, w1));
    @(posedge clk); @(negedge clk);
    chk(pin_out == grp(0, w2), "R1 R2 full word after one clock", pin_out, grp(0, w2));
    @(posedge clk) #1; drive_core(0, 0, 0, 1, 0, 2'd1, 9'h0AA);
    @(posedge clk); @(negedge clk);
    chk(pin_out == grp(0, 16'h12AA), "R1 cond/task/pc bits", pin_out, grp(0, 16'h12AA));
  endtask

  task automatic t_select();
    logic [15:0] w;
    w = 16'h12AA;
    cfg_write(1, 2'd2);
    chk(pin_oe == grp(2, 16'hFFFF), "R4 oe group 2", pin_oe, grp(2, 16'hFFFF));
    chk(pin_out == grp(2, w), "R4 R5 data only in group 2", pin_out, grp(2, w));
    cfg_write(1, 2'd3);
    chk(pin_oe == grp(3, 16'hFFFF), "R4 oe group 3", pin_oe, grp(3, 16'hFFFF));
    cfg_write(0, 2'd1);
    chk(pin_oe == 64'h0 && pin_out == 64'h0, "R5 disabled dark", pin_oe | pin_out, 64'h0);
  endtask

  task automatic t_secure();
    cfg_write(1, 2'd1);
    @(posedge clk) #1; sec_lock = 1;
    @(negedge clk);
    chk(pin_oe == 64'h0 && pin_out == 64'h0, "R6 lock darkens at once", pin_oe | pin_out, 64'h0);
    cfg_write(1, 2'd0);
    chk(pin_oe == 64'h0, "R6 write cannot enable under lock", pin_oe, 64'h0);
    @(posedge clk) #1; sec_lock = 0;
    @(negedge clk);
    chk(pin_oe == grp(0, 16'hFFFF), "R6 stored config after unlock", pin_oe, grp(0, 16'hFFFF));
  endtask

  task automatic t_step();
    int lows;
    @(posedge clk) #1; dbg_se = 1;
    @(negedge clk);
    chk(stall_req == 1, "R7 single-step stalls", {63'h0, stall_req}, 64'h1);
    @(posedge clk) #1; dbg_step = 1;
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!stall_req) lows++;
    end
    chk(lows == 1, "R7 long step frees one cycle", lows, 1);
    @(posedge clk) #1; dbg_step = 0;
    repeat (4) @(posedge clk);
    #1; dbg_step = 1;
    lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!stall_req) lows++;
    end
    chk(lows == 1, "R7 second edge frees one cycle", lows, 1);
    @(posedge clk) #1; dbg_step = 0; dbg_se = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_brk();
    #1; dbg_be = 1; dbg_brk = 9'h040; core_pc = 9'h010;
    @(negedge clk);
    chk(stall_req == 0, "R8 no stall off address", {63'h0, stall_req}, 64'h0);
    @(posedge clk) #1; core_pc = 9'h040;
    @(negedge clk);
    chk(stall_req == 1, "R8 same-cycle hit", {63'h0, stall_req}, 64'h1);
    @(posedge clk) #1; core_pc = 9'h041;
    @(negedge clk);
    chk(stall_req == 1, "R9 hold while PC moves", {63'h0, stall_req}, 64'h1);
    @(posedge clk) #1; core_pc = 9'h040;
    repeat (2) @(posedge clk);
    #1; dbg_step = 1;
    @(negedge clk);
    chk(stall_req == 1, "R9 held until pulse", {63'h0, stall_req}, 64'h1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(stall_req == 0, "R9 R10 released by step, no refire", {63'h0, stall_req}, 64'h0);
    @(posedge clk) #1; dbg_step = 0; core_pc = 9'h041;
    @(posedge clk) #1; core_pc = 9'h040;
    @(negedge clk);
    chk(stall_req == 1, "R10 refire after pass", {63'h0, stall_req}, 64'h1);
    @(posedge clk) #1; dbg_be = 0;
    @(negedge clk);
    chk(stall_req == 0, "R9 released by BE low", {63'h0, stall_req}, 64'h0);
    @(posedge clk) #1; dbg_be = 1;
    @(negedge clk);
    chk(stall_req == 0, "R10 no refire without pass", {63'h0, stall_req}, 64'h0);
    @(posedge clk) #1; core_pc = 9'h041;
    @(posedge clk) #1; core_pc = 9'h040;
    @(negedge clk);
    chk(stall_req == 1, "R10 fires after pass", {63'h0, stall_req}, 64'h1);
    @(posedge clk) #1; dbg_be = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset();
    t_layout();
    t_select();
    t_secure();
    t_step();
    t_brk();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule